// File: doc/BRIEF.md
# Region-Relocatable Four-Bank Word Store

This block is a 32-word, 4-bit-wide storage system that sits on a 7-bit address bus. The storage is split into four banks of eight words. The three lowest address bits are fanned out to every bank and choose a word inside a bank. The next two bits drive a 2-to-4 decoder that produces one active-low select per bank. The two highest bits are compared with a 2-bit region input. The decoder is enabled only when they match, so the whole store can be placed in any quarter of the 128-location space.

All banks share one write strobe and one read strobe, and their data lines are joined in parallel. A real shared bus would float when nothing is selected. Here the read output is forced to zero instead, and a separate hit flag reports whether the current address falls inside the store. Writes are taken on the rising clock edge, and reads are combinational. Reset clears every word.

Top module: `banked_ram_top`

## Requirements
- R1: While rst_n is low every word is cleared to 0. After reset, a read of any of the 32 locations returns 0.
- R2: When addr[6:5] equals region, exactly one select is low: cs_n[addr[4:3]]. The other three are high.
- R3: When addr[6:5] differs from region, all four cs_n bits are high.
- R4: hit is high exactly when addr[6:5] equals region, whatever the strobes are.
- R5: On a rising clock edge with wr_en high and hit high, wdata is stored in bank addr[4:3] at word addr[2:0]. It reads back from the following cycle on.
- R6: A write strobe while hit is low changes no stored word.
- R7: With rd_en high, wr_en low and hit high, rdata shows the addressed word in the same cycle, with no clock edge in between.
- R8: rdata is 0 whenever hit is low or rd_en is low.
- R9: A write changes only the addressed word. The same word offset in the other three banks keeps its value.
- R10: Changing region moves the store. Stored contents then appear at the addresses whose bits [4:0] are the same and whose top bits equal the new region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Active-low reset, clears storage |
| addr | input | 7 | Bus address: [2:0] word, [4:3] bank, [6:5] region tag |
| wdata | input | 4 | Write data |
| rd_en | input | 1 | Shared read strobe |
| wr_en | input | 1 | Shared write strobe (wins over rd_en) |
| region | input | 2 | Quarter of the address space the store occupies |
| rdata | output | 4 | Read data, 0 when not hit or not reading |
| hit | output | 1 | Address lies inside the store |
| cs_n | output | 4 | Active-low per-bank selects |

## Verification
The bench writes while the address is outside the region, then reads back all 32 words. A decoder that ignored its enable would have corrupted a bank in this step. It fills one word offset with four distinct values, one per bank, which exposes a bank index that is swapped or truncated. A design that read from a fixed bank would return the wrong one of those values. It moves the region after filling the store and reads the data at the new addresses, which catches a region compare that was wired to constants. Random traffic with a changing region checks that rdata stays 0 on misses and idle cycles, since a missing read gate would leak stale words.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 4;
    localparam int WORD_BITS = 3;
    localparam int BANK_BITS = 2;
    localparam int TAG_BITS  = ADDR_W - WORD_BITS - BANK_BITS;
    localparam int NUM_BANKS = 1 << BANK_BITS;
    localparam int DEPTH     = 1 << WORD_BITS;

    typedef logic [DATA_W-1:0]    word_t;
    typedef logic [WORD_BITS-1:0] woff_t;
    typedef logic [BANK_BITS-1:0] bidx_t;
    typedef logic [TAG_BITS-1:0]  tag_t;
endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int TAG_W = 2
) (
    input  logic [TAG_W-1:0] tag_bits,
    input  logic [TAG_W-1:0] region,
    output logic             match
);
    logic [TAG_W-1:0] agree;

    generate
        for (genvar b = 0; b < TAG_W; b++) begin : g_bit
            assign agree[b] = ~(tag_bits[b] ^ region[b]);
        end
    endgenerate

    assign match = &agree;
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder #(
    parameter int SEL_W = 2,
    localparam int OUTS = 1 << SEL_W
) (
    input  logic             enable,
    input  logic [SEL_W-1:0] sel,
    output logic [OUTS-1:0]  cs_n
);
    generate
        for (genvar i = 0; i < OUTS; i++) begin : g_out
            assign cs_n[i] = ~(enable && (sel == SEL_W'(i)));
        end
    endgenerate
endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int DATA_W    = 4,
    parameter int WORD_BITS = 3,
    localparam int DEPTH    = 1 << WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] woff,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    word_out
);
    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                store[k] <= '0;
            end
        end else if (!sel_n && wr_en) begin
            store[woff] <= wdata;
        end
    end

    assign word_out = store[woff];
endmodule

// File: rtl/banked_ram_top.sv
module banked_ram_top
    import banked_ram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [TAG_BITS-1:0] region,
    output logic [DATA_W-1:0] rdata,
    output logic              hit,
    output logic [NUM_BANKS-1:0] cs_n
);
    woff_t woff;
    bidx_t bidx;
    tag_t  tag;
    logic  dec_en;

    assign woff = addr[WORD_BITS-1:0];
    assign bidx = addr[WORD_BITS+BANK_BITS-1:WORD_BITS];
    assign tag  = addr[ADDR_W-1:WORD_BITS+BANK_BITS];

    region_match #(.TAG_W(TAG_BITS)) u_match (
        .tag_bits (tag),
        .region   (region),
        .match    (dec_en)
    );

    bank_decoder #(.SEL_W(BANK_BITS)) u_dec (
        .enable (dec_en),
        .sel    (bidx),
        .cs_n   (cs_n)
    );

    word_t bank_word [NUM_BANKS];
    word_t gated     [NUM_BANKS];

    generate
        for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
            ram_bank #(.DATA_W(DATA_W), .WORD_BITS(WORD_BITS)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel_n    (cs_n[i]),
                .wr_en    (wr_en),
                .woff     (woff),
                .wdata    (wdata),
                .word_out (bank_word[i])
            );
            assign gated[i] = cs_n[i] ? '0 : bank_word[i];
        end
    endgenerate

    always_comb begin
        word_t acc;
        acc = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            acc = acc | gated[i];
        end
        rdata = rd_en ? acc : '0;
    end

    assign hit = ~(&cs_n);
endmodule

// File: rtl/banked_ram_chk.sv
module banked_ram_chk
    import banked_ram_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic                 rd_en,
    input logic                 wr_en,
    input logic [TAG_BITS-1:0]  region,
    input logic [DATA_W-1:0]    rdata,
    input logic                 hit,
    input logic [NUM_BANKS-1:0] cs_n
);
    localparam int TOP = ADDR_W - 1;
    localparam int LOW = WORD_BITS + BANK_BITS;

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_cs_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[TOP:LOW] == region) |-> (cs_n[addr[LOW-1:WORD_BITS]] == 1'b0));

    assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[TOP:LOW] != region) |-> (&cs_n));

    assert_hit_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (addr[TOP:LOW] == region));

    assert_rdata_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit || !rd_en) |-> (rdata == '0));

    assert_write_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && $past(rst_n) && $past(hit && wr_en)
         && $stable(addr) && $stable(region)) |-> (rdata == $past(wdata)));
endmodule

bind banked_ram_top banked_ram_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .wdata  (wdata),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .region (region),
    .rdata  (rdata),
    .hit    (hit),
    .cs_n   (cs_n)
);

// File: tb/banked_ram_top_tb.sv
module banked_ram_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic [3:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] region = '0;
    logic [3:0] rdata;
    logic       hit;
    logic [3:0] cs_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [3:0] model [32];

    always #5 clk = ~clk;

    banked_ram_top u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .region(region),
        .rdata(rdata), .hit(hit), .cs_n(cs_n)
    );

    function automatic bit exp_hit(logic [6:0] a, logic [1:0] rg);
        return a[6:5] == rg;
    endfunction

    function automatic logic [3:0] exp_cs(logic [6:0] a, logic [1:0] rg);
        logic [3:0] c;
        c = 4'hF;
        if (exp_hit(a, rg)) c[a[4:3]] = 1'b0;
        return c;
    endfunction

    function automatic logic [3:0] exp_rd(logic [6:0] a, logic [1:0] rg, bit rd);
        if (!rd || !exp_hit(a, rg)) return 4'h0;
        return model[a[4:0]];
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, check combinational outputs, commit the write at posedge.
    task automatic step(string req, logic [6:0] a, logic [3:0] d, bit rd, bit wr, logic [1:0] rg);
        @(negedge clk);
        addr = a; wdata = d; rd_en = rd; wr_en = wr; region = rg;
        #1;
        check({req, " cs_n (R2/R3)"}, cs_n, exp_cs(a, rg));
        check({req, " hit (R4)"}, {3'b0, hit}, {3'b0, exp_hit(a, rg)});
        if (!wr) check({req, " rdata (R7/R8)"}, rdata, exp_rd(a, rg, rd));
        @(posedge clk);
        if (wr && exp_hit(a, rg)) model[a[4:0]] = d;
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset cs_n", cs_n, exp_cs(addr, region));
        check("R1 reset rdata", rdata, 4'h0);
        rst_n = 1'b1;

        // R1: every word reads zero after reset
        for (int i = 0; i < 32; i++) step("R1", {2'b00, 5'(i)}, 4'h0, 1'b1, 1'b0, 2'b00);

        // R9: same offset, distinct value per bank
        for (int b = 0; b < 4; b++) step("R9 wr", {2'b00, 2'(b), 3'd5}, 4'(b + 9), 1'b0, 1'b1, 2'b00);
        for (int b = 0; b < 4; b++) step("R9 rd", {2'b00, 2'(b), 3'd5}, 4'h0, 1'b1, 1'b0, 2'b00);

        // R5: write then read back immediately
        step("R5 wr", 7'b00_11_010, 4'hC, 1'b0, 1'b1, 2'b00);
        step("R5 rd", 7'b00_11_010, 4'h0, 1'b1, 1'b0, 2'b00);

        // R6: writes outside the region change nothing
        for (int i = 0; i < 32; i++) step("R6 wr", {2'b10, 5'(i)}, 4'hF, 1'b0, 1'b1, 2'b00);
        for (int i = 0; i < 32; i++) step("R6 rd", {2'b00, 5'(i)}, 4'h0, 1'b1, 1'b0, 2'b00);

        // R10: move region, data follows
        for (int i = 0; i < 32; i++) step("R10", {2'b11, 5'(i)}, 4'h0, 1'b1, 1'b0, 2'b11);
        step("R10 old", 7'b00_11_010, 4'h0, 1'b1, 1'b0, 2'b11);

        // R8: idle read strobe low inside region
        step("R8 idle", 7'b11_00_101, 4'h0, 1'b0, 1'b0, 2'b11);

        // random traffic, fixed seed
        void'($urandom(32'd7741));
        for (int n = 0; n < 1500; n++) begin
            logic [6:0] a;
            logic [3:0] d;
            logic [1:0] rg;
            int op;
            a  = 7'($urandom);
            d  = 4'($urandom);
            rg = (n % 200 < 150) ? 2'b01 : 2'($urandom);
            if ($urandom % 2 == 0) a[6:5] = rg;
            op = int'($urandom % 3);
            step("R7 rnd", a, d, op == 1, op == 2, rg);
        end

        // full sweep against model at the final region
        for (int i = 0; i < 32; i++) step("R9 sweep", {2'b01, 5'(i)}, 4'h0, 1'b1, 1'b0, 2'b01);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule